// File: doc/BRIEF.md
# Multiplexed-Bus Read Cycle Sequencer

This block performs one read transaction on an eight-bit multiplexed address/data bus of the four-state kind, on behalf of a simple on-chip requester. The requester hands over a 20-bit address and a 3-bit active-low status code. The block splits the address across two dedicated address groups and the shared AD byte. It then drives the status code so that an external bus controller can produce the address latch and command strobes. It steps through T1, T2, T3, any number of wait states and T4, and returns the captured byte to the requester.

The block also generates the bus clock it works to. It runs at a fraction of the system clock: every half period lasts `HALF_PERIOD` system clocks. Bus-side outputs change on falling bus-clock edges. The READY input and the AD byte are sampled on the rising edge inside T3 and each wait state. The request side is a valid/ready port. `req_ready` is high only while the sequencer is idle, so a request offered during a cycle is refused and has no effect. The response side has no back-pressure. `rsp_valid` is a single-clock pulse and `rsp_data` holds its value until the next read completes.

Top module: `mux_bus_reader`

## Requirements
- R1: While `rst` is high and after it falls, `bus_stat_n` is 3'b111 (passive), `bus_ad_oe` is 1, `req_ready` is 1 and `rsp_valid` is 0. A reset in mid-cycle returns the sequencer to these values.
- R2: A request is accepted on a clock with `req_valid` and `req_ready` both high. On the following clock, address bits 19..16 appear on `bus_a_hi`, bits 15..8 appear on `bus_a_mid` and bits 7..0 appear on `bus_ad_out`, while the status is still passive. A request offered during a cycle is refused (`req_ready` 0) and leaves the address outputs unchanged.
- R3: At the first falling bus-clock edge after acceptance (start of T1), `bus_stat_n` takes the requested code, with `bus_ad_oe` still 1. The code holds through T1, T2, T3 and every wait state.
- R4: At the falling edge that starts T2, `bus_ad_oe` drops to 0. It stays 0 through T3, the wait states and T4.
- R5: `bus_ready` is sampled at the rising edge in T3 and in each wait state. If it is low, the next falling edge begins one more wait state of a full bus clock.
- R6: The byte on `bus_ad_in` at the rising edge where `bus_ready` is seen high is the byte returned on `rsp_data`. Later changes on `bus_ad_in` do not alter it.
- R7: At the falling edge after READY is seen high, `bus_stat_n` returns to 3'b111 and T4 begins. From T1 start to T4 start there are (3 + waits) bus clocks, so a cycle with no waits spans exactly four bus clocks.
- R8: At the falling edge ending T4, `bus_ad_oe` returns to 1 and `rsp_valid` rises with the captured byte on `rsp_data`.
- R9: `bus_clk` has a period of 2*HALF_PERIOD system clocks. `bus_stat_n` changes only on clocks where `bus_clk` falls.
- R10: `rsp_valid` is high for exactly one system clock per completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester offers a read |
| req_ready | output | 1 | Sequencer idle and able to take a read |
| req_status | input | STAT_W | Active-low status code for the cycle |
| req_addr | input | ADDR_W | Byte address to read |
| rsp_valid | output | 1 | One-clock pulse: read finished |
| rsp_data | output | DATA_W | Byte captured during the cycle |
| bus_clk | output | 1 | Generated bus clock |
| bus_ready | input | 1 | Device ready; low inserts wait states |
| bus_ad_in | input | DATA_W | Read value of the multiplexed AD byte |
| bus_stat_n | output | STAT_W | Active-low status lines, all ones when passive |
| bus_a_hi | output | ADDR_W-MID_W-DATA_W | Top address bits |
| bus_a_mid | output | MID_W | Middle address byte |
| bus_ad_out | output | DATA_W | Low address byte driven on the AD pins |
| bus_ad_oe | output | 1 | AD output enable (1 = drive) |

## Verification
The bench builds the block with its default widths and `HALF_PERIOD` = 2. A bus clock then spans four system clocks, so the distinct rising-edge sample and falling-edge advance fall on separate system clocks and can be observed one at a time. Wait counts from zero to six reach both the minimum four-clock cycle and long stretched cycles. A reset issued in T2 and requests offered in mid-cycle cover the abort and refusal paths.

// File: rtl/busseq_pkg.sv
package busseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PREP = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5
  } phase_e;
endpackage

// File: rtl/busseq_clkgen.sv
module busseq_clkgen #(
  parameter int HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst,
  output logic bclk,
  output logic rise_en,
  output logic fall_en
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == CW'(HALF_PERIOD - 1));
  assign rise_en = wrap & ~bclk;
  assign fall_en = wrap & bclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  AST_FALL_LOWERS: assert property (@(posedge clk) disable iff (rst)
    fall_en |=> !bclk); // R9
  AST_RISE_RAISES: assert property (@(posedge clk) disable iff (rst)
    rise_en |=> bclk); // R9
endmodule

// File: rtl/busseq_sampler.sv
module busseq_sampler #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_en,
  input  logic              window,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rdy_seen,
  output logic [DATA_W-1:0] data_seen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_seen  <= 1'b0;
      data_seen <= '0;
    end else if (!window) begin
      rdy_seen  <= 1'b0;
    end else if (rise_en) begin
      rdy_seen  <= ready_in;
      data_seen <= ad_in;
    end
  end

  AST_NO_STALE_READY: assert property (@(posedge clk) disable iff (rst)
    !window |=> !rdy_seen); // R5
  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (window && !rise_en) |=> $stable(data_seen)); // R6
endmodule

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
#(
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_en,
  input  logic              accept,
  input  logic [STAT_W-1:0] req_code,
  input  logic              rdy_seen,
  output phase_e            state,
  output logic              idle,
  output logic              finish,
  output logic [STAT_W-1:0] stat_n,
  output logic              ad_oe,
  output logic              done
);
  localparam logic [STAT_W-1:0] PASSIVE = '1;

  logic [STAT_W-1:0] code_q;

  assign idle   = (state == ST_IDLE);
  assign finish = (state == ST_T3) & fall_en & rdy_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      stat_n <= PASSIVE;
      ad_oe  <= 1'b1;
      code_q <= PASSIVE;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_PREP;
          code_q <= req_code;
        end
        ST_PREP: if (fall_en) begin
          state  <= ST_T1;
          stat_n <= code_q;
        end
        ST_T1: if (fall_en) begin
          state <= ST_T2;
          ad_oe <= 1'b0;
        end
        ST_T2: if (fall_en) state <= ST_T3;
        ST_T3: if (finish) begin
          state  <= ST_T4;
          stat_n <= PASSIVE;
        end
        ST_T4: if (fall_en) begin
          state <= ST_IDLE;
          ad_oe <= 1'b1;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PASSIVE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_PREP) |-> stat_n == PASSIVE); // R3
  AST_STAT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !fall_en |=> $stable(stat_n)); // R9
  AST_AD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T2 || state == ST_T3 || state == ST_T4) |-> !ad_oe); // R4
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T3 && fall_en && !rdy_seen) |=> (state == ST_T3 && stat_n != PASSIVE)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    done |-> ad_oe); // R8
endmodule

// File: rtl/busseq_addr.sv
module busseq_addr #(
  parameter int ADDR_W = 20,
  parameter int MID_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      capture,
  input  logic [DATA_W-1:0]         data_seen,
  output logic [ADDR_W-MID_W-DATA_W-1:0] a_hi,
  output logic [MID_W-1:0]          a_mid,
  output logic [DATA_W-1:0]         ad_out,
  output logic [DATA_W-1:0]         rdata
);
  localparam int LO_TOP  = DATA_W - 1;
  localparam int MID_BOT = DATA_W;
  localparam int MID_TOP = DATA_W + MID_W - 1;
  localparam int HI_BOT  = DATA_W + MID_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_hi   <= '0;
      a_mid  <= '0;
      ad_out <= '0;
    end else if (load) begin
      a_hi   <= addr[ADDR_W-1:HI_BOT];
      a_mid  <= addr[MID_TOP:MID_BOT];
      ad_out <= addr[LO_TOP:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (capture) rdata <= data_seen;
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({a_hi, a_mid, ad_out})); // R2
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(rdata)); // R6
endmodule

// File: rtl/mux_bus_reader.sv
module mux_bus_reader
  import busseq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int MID_W       = 8,
  parameter int DATA_W      = 8,
  parameter int STAT_W      = 3,
  parameter int HALF_PERIOD = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [STAT_W-1:0]             req_status,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          bus_clk,
  input  logic                          bus_ready,
  input  logic [DATA_W-1:0]             bus_ad_in,
  output logic [STAT_W-1:0]             bus_stat_n,
  output logic [ADDR_W-MID_W-DATA_W-1:0] bus_a_hi,
  output logic [MID_W-1:0]              bus_a_mid,
  output logic [DATA_W-1:0]             bus_ad_out,
  output logic                          bus_ad_oe
);
  logic              rise_en, fall_en;
  logic              accept, idle, finish, rdy_seen;
  logic [DATA_W-1:0] data_seen;
  phase_e            state;

  assign req_ready = idle;
  assign accept    = req_valid & idle;

  busseq_clkgen #(.HALF_PERIOD(HALF_PERIOD)) u_clk (
    .clk(clk), .rst(rst), .bclk(bus_clk), .rise_en(rise_en), .fall_en(fall_en)
  );

  busseq_sampler #(.DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst(rst), .rise_en(rise_en), .window(state == ST_T3),
    .ready_in(bus_ready), .ad_in(bus_ad_in),
    .rdy_seen(rdy_seen), .data_seen(data_seen)
  );

  busseq_fsm #(.STAT_W(STAT_W)) u_fsm (
    .clk(clk), .rst(rst), .fall_en(fall_en), .accept(accept),
    .req_code(req_status), .rdy_seen(rdy_seen), .state(state), .idle(idle),
    .finish(finish), .stat_n(bus_stat_n), .ad_oe(bus_ad_oe), .done(rsp_valid)
  );

  busseq_addr #(.ADDR_W(ADDR_W), .MID_W(MID_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst(rst), .load(accept), .addr(req_addr),
    .capture(finish), .data_seen(data_seen),
    .a_hi(bus_a_hi), .a_mid(bus_a_mid), .ad_out(bus_ad_out), .rdata(rsp_data)
  );

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !req_ready); // R2
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_stat_n) == '1 && bus_stat_n != '1) |-> !bus_clk); // R3
endmodule

// File: tb/mux_bus_reader_tb.sv
`timescale 1ns/1ps
module mux_bus_reader_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_status = 3'b111;
  logic [19:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        bus_clk;
  logic        bus_ready = 1'b0;
  logic [7:0]  bus_ad_in = '0;
  logic [2:0]  bus_stat_n;
  logic [3:0]  bus_a_hi;
  logic [7:0]  bus_a_mid;
  logic [7:0]  bus_ad_out;
  logic        bus_ad_oe;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mux_bus_reader #(.HALF_PERIOD(HALF)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_status(req_status), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .bus_clk(bus_clk), .bus_ready(bus_ready),
    .bus_ad_in(bus_ad_in), .bus_stat_n(bus_stat_n), .bus_a_hi(bus_a_hi),
    .bus_a_mid(bus_a_mid), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe)
  );

  function automatic logic [7:0] dev_byte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'hA};
  endfunction

  function automatic int span_clks(input int waits);
    return (3 + waits) * 2 * HALF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic next_fall();
    @(negedge bus_clk);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [19:0] a, input logic [2:0] code,
                         input int waits, input bit poke);
    logic [7:0] d;
    int t_start;
    d = dev_byte(a);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_status = code;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_status = 3'b111;
    chk("R2 a_hi", 32'(bus_a_hi), 32'(a[19:16]));
    chk("R2 a_mid", 32'(bus_a_mid), 32'(a[15:8]));
    chk("R2 ad_out", 32'(bus_ad_out), 32'(a[7:0]));
    chk("R2 status passive before T1", 32'(bus_stat_n), 32'h7);
    next_fall();
    t_start = cyc;
    chk("R3 T1 status", 32'(bus_stat_n), 32'(code));
    chk("R3 T1 oe", 32'(bus_ad_oe), 32'h1);
    next_fall();
    chk("R4 T2 oe", 32'(bus_ad_oe), 32'h0);
    chk("R3 T2 status", 32'(bus_stat_n), 32'(code));
    bus_ad_in = d;
    bus_ready = (waits == 0);
    if (poke) begin
      req_valid = 1'b1; req_addr = ~a; req_status = 3'b010;
      @(negedge clk);
      chk("R2 busy refused", 32'(req_ready), 32'h0);
      req_valid = 1'b0;
    end
    next_fall();
    chk("R3 T3 status", 32'(bus_stat_n), 32'(code));
    for (int k = 1; k <= waits; k++) begin
      next_fall();
      chk("R5 wait status", 32'(bus_stat_n), 32'(code));
      chk("R4 wait oe", 32'(bus_ad_oe), 32'h0);
      if (k == waits) bus_ready = 1'b1;
    end
    @(posedge bus_clk);
    @(negedge clk);
    bus_ad_in = ~d;
    bus_ready = 1'b0;
    next_fall();
    chk("R7 T4 status", 32'(bus_stat_n), 32'h7);
    chk("R7 cycle span", 32'(cyc - t_start), 32'(span_clks(waits)));
    chk("R4 T4 oe", 32'(bus_ad_oe), 32'h0);
    chk("R10 no early rsp", 32'(rsp_valid), 32'h0);
    next_fall();
    chk("R8 rsp_valid", 32'(rsp_valid), 32'h1);
    chk("R6 data", 32'(rsp_data), 32'(d));
    chk("R8 oe back", 32'(bus_ad_oe), 32'h1);
    chk("R2 address kept", 32'(bus_a_mid), 32'(a[15:8]));
    @(negedge clk);
    chk("R10 single pulse", 32'(rsp_valid), 32'h0);
    chk("R6 data held", 32'(rsp_data), 32'(d));
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'h5EED1));
    repeat (5) @(negedge clk);
    chk("R1 reset status", 32'(bus_stat_n), 32'h7);
    chk("R1 reset oe", 32'(bus_ad_oe), 32'h1);
    chk("R1 reset rsp", 32'(rsp_valid), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'h1);

    @(posedge bus_clk); @(negedge clk); t0 = cyc;
    @(posedge bus_clk); @(negedge clk);
    chk("R9 bus clock period", 32'(cyc - t0), 32'(2 * HALF));

    do_read(20'hFFFF0, 3'b101, 0, 1'b0);
    do_read(20'h00000, 3'b001, 6, 1'b1);
    do_read(20'hA5C3E, 3'b100, 1, 1'b1);

    // reset in T2
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = 20'h12345; req_status = 3'b101;
    @(negedge clk); req_valid = 1'b0;
    next_fall();
    next_fall();
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-cycle reset status", 32'(bus_stat_n), 32'h7);
    chk("R1 mid-cycle reset oe", 32'(bus_ad_oe), 32'h1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mid-cycle reset ready", 32'(req_ready), 32'h1);

    for (int n = 0; n < 30; n++) begin
      logic [19:0] ra;
      logic [2:0]  rc;
      ra = 20'($urandom);
      rc = 3'($urandom % 7);
      do_read(ra, rc, int'($urandom % 5), 1'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule